// File: doc/BRIEF.md
# ADC Channel Sweep Sequencer

This block controls a multiplexed ADC. It steps the converter through a contiguous run of 4-bit channel indices, from a first index to a last index. For every index it drives the analog multiplexer select and raises a one-cycle conversion request. It then waits out the conversion time that belongs to that channel, plus any delay in the converter's own done signal. When both have passed, it presents the captured result together with the index it belongs to, and pulses an end-of-conversion indication. The converter, the multiplexer and any configuration registers sit outside the block.

The indices are assigned as follows: 0 offset, 1 AIN0, 2 AIN1, 3 temperature, 4 reference, 5 supply PVDD, 6 supply VDD, 7 ZTAT, 8 output monitor. Every index from 9 to 15 selects ground. The two external inputs, AIN0 and AIN1, convert at one of four rates chosen by a 2-bit code. Every other index, ground included, converts at one fixed rate. Conversion times are counted in ADC clock ticks, and `TICK_DIV` system clock cycles make one tick.

In free-running mode the block starts the next sweep as soon as the previous one ends. In triggered mode it runs one sweep for each trigger and then goes idle. The whole configuration is copied at the start of each sweep, so a sweep always finishes with the settings it began with.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, `conv_start`, `res_valid`, `eoc` and `busy` are all low. After reset the sweep copy holds first index 0 and last index 8.
- R2: A sweep issues exactly one `conv_start` for each index from the first to the effective last, in ascending order. Each request after the first comes in the same cycle as the result of the index before it.
- R3: When the last index is below the first, the effective last index equals the first, so the sweep converts the first index only.
- R4: While a request is active, `mux_sel` equals the index for indices 0 to 8 and equals 9 for indices 9 to 15.
- R5: The conversion period is P = ticks × `TICK_DIV` cycles. For indices 1 and 2 the tick count is 20, 30, 60 or 120 for rate codes 0, 1, 2 and 3. For every other index it is 30. If `conv_done` arrives no later than P−1 cycles after the request, `res_valid` is high exactly P cycles after `conv_start`.
- R6: If `conv_done` arrives d ≥ P−1 cycles after the request, `res_valid` is high d+1 cycles after `conv_start`.
- R7: `res_idx` carries the converted index, and `res_data` carries the value `conv_data` had in the cycle `conv_done` was high.
- R8: With `cfg_eoc_each` = 0, `eoc` pulses only with the result of the effective last index. With `cfg_eoc_each` = 1, it pulses with every result. `eoc` is never high without `res_valid`.
- R9: With `cfg_direct` = 0, the next sweep's `conv_start` comes one cycle after the final result of the previous sweep, and no trigger is needed.
- R10: With `cfg_direct` = 1, a sweep starts only for a `trig` pulse seen while idle. A `trig` during a sweep is ignored, and after the sweep the block stays idle.
- R11: Changes to first index, last index, rate, EOC mode or trigger mode made during a sweep do not alter that sweep. The first index, last index, rate and EOC mode are sampled in the idle cycle that begins the next sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_idx | input | 4 | First index of the sweep |
| cfg_stop_idx | input | 4 | Last index of the sweep (clamped to the first index) |
| cfg_ain_rate | input | 2 | Rate code for indices 1 and 2 |
| cfg_eoc_each | input | 1 | 1: EOC after every result, 0: EOC once per sweep |
| cfg_direct | input | 1 | 1: triggered sweeps, 0: free-running |
| trig | input | 1 | Sweep trigger in triggered mode |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | DATA_W | Converter result, valid with `conv_done` |
| conv_start | output | 1 | One-cycle conversion request |
| mux_sel | output | 4 | Analog multiplexer select |
| res_valid | output | 1 | Result strobe |
| res_idx | output | 4 | Index of the presented result |
| res_data | output | DATA_W | Captured result |
| eoc | output | 1 | End-of-conversion pulse |
| busy | output | 1 | A sweep is in progress |

## Verification
A result is due max(P, d+1) cycles after its request, where d is the bench converter's done delay. The bench computes P from the index and the rate code of the sweep, and compares the result's arrival cycle with that value exactly. The next request is due in the result's own cycle. A free-running restart is due one cycle after the final result. A triggered sweep starts in the cycle after `trig`. A monitor samples at the falling edge and keeps its own copy of the configuration from one cycle earlier. This copy matches what the block samples in its idle cycle, so each sweep is checked against the settings it truly started with.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned IDX_BITS   = 4;
   localparam int unsigned RATE_BITS  = 2;
   localparam int unsigned RATE_CODES = 1 << RATE_BITS;
   localparam int unsigned DEF_FIRST  = 0;
   localparam int unsigned DEF_LAST   = 8;

   typedef logic [IDX_BITS-1:0]  idx_t;
   typedef logic [RATE_BITS-1:0] rate_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_e;

   typedef struct packed {
      idx_t  first;
      idx_t  last;
      rate_t rate;
      logic  eoc_each;
   } sweep_cfg_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_period.sv
module adc_seq_period
   import adc_seq_pkg::*;
#(
   parameter int unsigned TICK_DIV  = 4,
   parameter int unsigned AIN_FIRST = 1,
   parameter int unsigned AIN_LAST  = 2,
   parameter int unsigned T_R0      = 20,
   parameter int unsigned T_R1      = 30,
   parameter int unsigned T_R2      = 60,
   parameter int unsigned T_R3      = 120,
   parameter int unsigned T_FIXED   = 30,
   parameter int unsigned CNT_W     = 12
) (
   input  idx_t             idx,
   input  rate_t            rate,
   output logic [CNT_W-1:0] period
);

   localparam int unsigned TICKS [RATE_CODES] = '{T_R0, T_R1, T_R2, T_R3};
   localparam int unsigned FIX_CYC = T_FIXED * TICK_DIV;

   logic [CNT_W-1:0] rate_cyc [RATE_CODES];
   logic             is_ext;

   for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
      localparam int unsigned CYC = TICKS[g] * TICK_DIV;
      if (CYC < 2) begin : g_bad
         $error("conversion period for rate code %0d is below two cycles", g);
      end
      if (CYC >= (1 << CNT_W)) begin : g_wide
         $error("conversion period for rate code %0d does not fit the counter", g);
      end
      assign rate_cyc[g] = CNT_W'(CYC);
   end

   if (FIX_CYC < 2) begin : g_fix_bad
      $error("fixed conversion period is below two cycles");
   end

   assign is_ext = (32'(idx) >= AIN_FIRST) && (32'(idx) <= AIN_LAST);

   always_comb begin
      if (is_ext) period = rate_cyc[rate];
      else        period = CNT_W'(FIX_CYC);
   end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] period,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= period - CNT_W'(2);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_mux_map.sv
module adc_seq_mux_map
   import adc_seq_pkg::*;
#(
   parameter int unsigned LAST_CH = 8,
   parameter int unsigned GND_SEL = 9
) (
   input  idx_t idx,
   output idx_t sel
);

   localparam int unsigned IDX_MAX = (1 << IDX_BITS) - 1;

   if (GND_SEL > IDX_MAX) begin : g_gnd_bad
      $error("ground select code does not fit the index width");
   end

   if (LAST_CH >= IDX_MAX) begin : g_all_real
      assign sel = idx;
   end else begin : g_with_gnd
      assign sel = (32'(idx) > LAST_CH) ? IDX_BITS'(GND_SEL) : idx;
   end

endmodule

// File: rtl/adc_seq_snap.sv
module adc_seq_snap
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  idx_t       first_in,
   input  idx_t       last_in,
   input  rate_t      rate_in,
   input  logic       eoc_each_in,
   output sweep_cfg_t cfg
);

   idx_t eff_last;

   assign eff_last = (last_in < first_in) ? first_in : last_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.first    <= IDX_BITS'(DEF_FIRST);
         cfg.last     <= IDX_BITS'(DEF_LAST);
         cfg.rate     <= '0;
         cfg.eoc_each <= 1'b0;
      end else if (load) begin
         cfg.first    <= first_in;
         cfg.last     <= eff_last;
         cfg.rate     <= rate_in;
         cfg.eoc_each <= eoc_each_in;
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned TICK_DIV  = 4,
   parameter int unsigned LAST_CH   = 8,
   parameter int unsigned GND_SEL   = 9,
   parameter int unsigned AIN_FIRST = 1,
   parameter int unsigned AIN_LAST  = 2,
   parameter int unsigned T_R0      = 20,
   parameter int unsigned T_R1      = 30,
   parameter int unsigned T_R2      = 60,
   parameter int unsigned T_R3      = 120,
   parameter int unsigned T_FIXED   = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cfg_start_idx,
   input  logic [3:0]        cfg_stop_idx,
   input  logic [1:0]        cfg_ain_rate,
   input  logic              cfg_eoc_each,
   input  logic              cfg_direct,
   input  logic              trig,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              conv_start,
   output logic [3:0]        mux_sel,
   output logic              res_valid,
   output logic [3:0]        res_idx,
   output logic [DATA_W-1:0] res_data,
   output logic              eoc,
   output logic              busy
);

   localparam int unsigned MAX_T =
      max_u(max_u(max_u(T_R0, T_R1), max_u(T_R2, T_R3)), T_FIXED);
   localparam int unsigned MAX_P = MAX_T * TICK_DIV;
   localparam int unsigned CNT_W = $clog2(MAX_P + 1);

   if (TICK_DIV < 1) begin : g_div_bad
      $error("TICK_DIV must be at least one");
   end
   if (AIN_LAST < AIN_FIRST) begin : g_ain_bad
      $error("external channel range is empty");
   end
   if (DATA_W < 1) begin : g_data_bad
      $error("DATA_W must be at least one");
   end

   seq_state_e        state_q;
   idx_t              cur_q;
   logic              done_seen_q;
   logic [DATA_W-1:0] data_q;
   sweep_cfg_t        cfg;
   logic              go;
   logic              snap_load;
   logic              tmr_load;
   logic              tmr_expired;
   logic              fire;
   logic              at_last;
   logic [CNT_W-1:0]  period;

   assign go        = cfg_direct ? trig : 1'b1;
   assign snap_load = (state_q == ST_IDLE) && go;
   assign tmr_load  = (state_q == ST_CONV);
   assign at_last   = (cur_q == cfg.last);
   assign fire      = (state_q == ST_WAIT) && tmr_expired && (done_seen_q || conv_done);

   adc_seq_snap u_snap (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (snap_load),
      .first_in    (cfg_start_idx),
      .last_in     (cfg_stop_idx),
      .rate_in     (cfg_ain_rate),
      .eoc_each_in (cfg_eoc_each),
      .cfg         (cfg)
   );

   adc_seq_period #(
      .TICK_DIV  (TICK_DIV),
      .AIN_FIRST (AIN_FIRST),
      .AIN_LAST  (AIN_LAST),
      .T_R0      (T_R0),
      .T_R1      (T_R1),
      .T_R2      (T_R2),
      .T_R3      (T_R3),
      .T_FIXED   (T_FIXED),
      .CNT_W     (CNT_W)
   ) u_period (
      .idx    (cur_q),
      .rate   (cfg.rate),
      .period (period)
   );

   adc_seq_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .period  (period),
      .expired (tmr_expired)
   );

   adc_seq_mux_map #(
      .LAST_CH (LAST_CH),
      .GND_SEL (GND_SEL)
   ) u_mux (
      .idx (cur_q),
      .sel (mux_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_q       <= IDX_BITS'(DEF_FIRST);
         done_seen_q <= 1'b0;
         data_q      <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  cur_q   <= cfg_start_idx;
                  state_q <= ST_CONV;
               end
            end
            ST_CONV: begin
               done_seen_q <= 1'b0;
               state_q     <= ST_WAIT;
            end
            ST_WAIT: begin
               if (conv_done) begin
                  done_seen_q <= 1'b1;
                  data_q      <= conv_data;
               end
               if (fire) begin
                  if (at_last) begin
                     state_q <= ST_IDLE;
                  end else begin
                     cur_q   <= cur_q + IDX_BITS'(1);
                     state_q <= ST_CONV;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         eoc       <= 1'b0;
         res_idx   <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= fire;
         eoc       <= fire && (cfg.eoc_each || at_last);
         if (fire) begin
            res_idx  <= cur_q;
            res_data <= conv_done ? conv_data : data_q;
         end
      end
   end

   assign conv_start = (state_q == ST_CONV);
   assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int unsigned GND_SEL = 9
) (
   input logic       clk,
   input logic       rst_n,
   input logic       conv_start,
   input logic       res_valid,
   input logic       eoc,
   input logic       busy,
   input logic [3:0] mux_sel,
   input logic       trig,
   input logic       cfg_direct
);

   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   assert_mux_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(mux_sel) <= GND_SEL);

   assert_no_early_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !res_valid);

   assert_result_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_eoc_with_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> res_valid);

   assert_direct_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_direct && !trig) |=> !conv_start);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.GND_SEL(GND_SEL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .res_valid  (res_valid),
   .eoc        (eoc),
   .busy       (busy),
   .mux_sel    (mux_sel),
   .trig       (trig),
   .cfg_direct (cfg_direct)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_start_idx = 4'd0;
   logic [3:0]  cfg_stop_idx = 4'd8;
   logic [1:0]  cfg_ain_rate = 2'd0;
   logic        cfg_eoc_each = 1'b0;
   logic        cfg_direct = 1'b1;
   logic        trig = 1'b0;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = 16'd0;
   logic        conv_start;
   logic [3:0]  mux_sel;
   logic        res_valid;
   logic [3:0]  res_idx;
   logic [15:0] res_data;
   logic        eoc;
   logic        busy;

   always #2.5 clk = ~clk;

   adc_seq_ctrl #(.DATA_W(16), .TICK_DIV(1)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_start_idx (cfg_start_idx),
      .cfg_stop_idx  (cfg_stop_idx),
      .cfg_ain_rate  (cfg_ain_rate),
      .cfg_eoc_each  (cfg_eoc_each),
      .cfg_direct    (cfg_direct),
      .trig          (trig),
      .conv_done     (conv_done),
      .conv_data     (conv_data),
      .conv_start    (conv_start),
      .mux_sel       (mux_sel),
      .res_valid     (res_valid),
      .res_idx       (res_idx),
      .res_data      (res_data),
      .eoc           (eoc),
      .busy          (busy)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int period_of(input int idx, input int rate);
      if (idx == 1 || idx == 2) begin
         case (rate)
            0:       return 20;
            1:       return 30;
            2:       return 60;
            default: return 120;
         endcase
      end
      return 30;
   endfunction

   // monitor and converter model state
   int cyc = 0;
   int c_start = 0, cur_p = 0, cur_dly = 1, exp_t = 0;
   int sw_first = 0, sw_last = 0, sw_rate = 0, cur = 0, n_conv = 0;
   bit sw_each = 0, sw_clamped = 0;
   int next_at = -1, restart_at = -1;
   bit sweep_on = 0, in_conv = 0;
   int sweeps_done = 0, starts_seen = 0, last_final_idx = -1;
   int trig_req = 0, trig_used = 0;
   int dly_cfg = 1;
   bit pend = 0;
   int dcnt = 0;
   logic [15:0] drv_data = 16'd0;
   logic [3:0] p_start = 4'd0, p_stop = 4'd8;
   logic [1:0] p_rate = 2'd0;
   logic p_each = 1'b0, p_direct = 1'b1;
   bit legal;
   int exp_mux;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         // R1: outputs quiet in reset
         chk(!conv_start && !res_valid && !eoc && !busy, "R1 reset outputs",
             int'({conv_start, res_valid, eoc, busy}), 0);
      end else begin
         if (res_valid) begin
            if (!in_conv) begin
               chk(0, "R5 result without request", 1, 0);
            end else begin
               exp_t = c_start + ((cur_p > cur_dly + 1) ? cur_p : cur_dly + 1);
               chk(cyc == exp_t, (cur_dly + 1 > cur_p) ? "R6 late result timing" : "R5 result timing",
                   cyc - c_start, exp_t - c_start);
               chk(int'(res_idx) == cur, "R7 result index", int'(res_idx), cur);
               chk(res_data == drv_data, "R7 result data", int'(res_data), int'(drv_data));
               chk(eoc == (sw_each || cur == sw_last), "R8 eoc mode", int'(eoc),
                   int'(sw_each || cur == sw_last));
               in_conv = 0;
               if (cur == sw_last) begin
                  chk(n_conv == sw_last - sw_first + 1,
                      sw_clamped ? "R3 clamped sweep length" : "R2 sweep length",
                      n_conv, sw_last - sw_first + 1);
                  sweep_on = 0;
                  sweeps_done++;
                  last_final_idx = cur;
                  restart_at = cfg_direct ? -1 : cyc + 1;
                  next_at = -1;
               end else begin
                  cur++;
                  next_at = cyc;
               end
            end
         end else if (eoc) begin
            chk(0, "R8 eoc without result", 1, 0);
         end

         if (conv_start) begin
            starts_seen++;
            if (!sweep_on) begin
               legal = (p_direct == 1'b0) || (trig_req != trig_used);
               chk(legal, "R10 sweep start legality", int'(legal), 1);
               trig_used = trig_req;
               if (restart_at >= 0) chk(cyc == restart_at, "R9 auto restart cycle", cyc, restart_at);
               restart_at = -1;
               sw_first = int'(p_start);
               sw_clamped = (p_stop < p_start);
               sw_last = sw_clamped ? int'(p_start) : int'(p_stop);
               sw_rate = int'(p_rate);
               sw_each = p_each;
               cur = sw_first;
               n_conv = 0;
               sweep_on = 1;
            end else begin
               chk(cyc == next_at && !in_conv, "R2 next request cycle", cyc, next_at);
            end
            exp_mux = (cur > 8) ? 9 : cur;
            chk(int'(mux_sel) == exp_mux, "R4 mux select", int'(mux_sel), exp_mux);
            n_conv++;
            c_start = cyc;
            cur_p = period_of(cur, sw_rate);
            cur_dly = dly_cfg;
            in_conv = 1;
         end else begin
            if (restart_at == cyc) begin
               chk(0, "R9 missing auto restart", 0, 1);
               restart_at = -1;
            end
            if (sweep_on && !in_conv && next_at == cyc) chk(0, "R2 missing request", 0, 1);
         end

         // converter model: done strobe dly cycles after the request
         conv_done = 1'b0;
         if (pend) begin
            if (dcnt == 0) begin
               conv_done = 1'b1;
               conv_data = 16'(cyc * 13 + 16'h3A5);
               drv_data = conv_data;
               pend = 0;
            end else begin
               dcnt--;
            end
         end
         if (conv_start) begin
            pend = 1;
            dcnt = cur_dly - 1;
         end
      end
      p_start = cfg_start_idx;
      p_stop = cfg_stop_idx;
      p_rate = cfg_ain_rate;
      p_each = cfg_eoc_each;
      p_direct = cfg_direct;
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic fire_trig(input bit counted);
      tick();
      trig = 1'b1;
      if (counted) trig_req++;
      tick();
      trig = 1'b0;
   endtask

   initial begin
      int n;
      int s0;
      int dtab [4] = '{1, 6, 29, 125};
      repeat (4) tick();
      rst_n = 1'b1;
      repeat (20) tick();
      chk(!busy && starts_seen == 0, "R10 idle after reset in triggered mode", starts_seen, 0);

      // exhaustive triggered sweeps over every first/last pair
      for (int s = 0; s < 16; s++) begin
         for (int e = 0; e < 16; e++) begin
            tick();
            cfg_start_idx = 4'(s);
            cfg_stop_idx = 4'(e);
            cfg_ain_rate = 2'((s + e) % 4);
            cfg_eoc_each = e[0];
            dly_cfg = dtab[(s + 2 * e) % 4];
            n = sweeps_done;
            fire_trig(1'b1);
            if (s == 0 && e == 15) begin
               repeat (50) tick();
               fire_trig(1'b0); // R10: ignored while busy
            end
            wait (sweeps_done != n);
            repeat (3) tick();
         end
      end
      s0 = starts_seen;
      repeat (150) tick();
      chk(starts_seen == s0, "R10 stray trigger ignored", starts_seen, s0);

      // free-running mode with a mid-sweep configuration change
      cfg_start_idx = 4'd1;
      cfg_stop_idx = 4'd3;
      cfg_ain_rate = 2'd2;
      cfg_eoc_each = 1'b0;
      dly_cfg = 3;
      cfg_direct = 1'b0;
      n = sweeps_done;
      wait (sweeps_done == n + 2);
      @(negedge clk);
      while (!(res_valid && !eoc)) @(negedge clk);
      tick();
      cfg_start_idx = 4'd7;
      cfg_stop_idx = 4'd5;
      cfg_ain_rate = 2'd1;
      cfg_eoc_each = 1'b1;
      n = sweeps_done;
      wait (sweeps_done == n + 1);
      chk(last_final_idx == 3, "R11 running sweep keeps its range", last_final_idx, 3);
      wait (sweeps_done == n + 2);
      chk(last_final_idx == 7, "R11 new range used next sweep", last_final_idx, 7);
      wait (sweeps_done == n + 3);
      tick();
      cfg_direct = 1'b1;
      n = sweeps_done;
      wait (sweeps_done == n + 1);
      s0 = starts_seen;
      repeat (300) tick();
      chk(starts_seen == s0, "R10 stays idle after switch to triggered", starts_seen, s0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule